// File: doc/BRIEF.md
# Vector Length Grant Unit

This unit executes the instruction that sets the vector length. When the execute strobe is high it takes the requested element count from the rs1 operand and the register-file allocation from the immediate, and grants a vector length. The grant is not a plain minimum of request and allocation. A request of more than twice the allocation saturates to XLEN. A request above the allocation but not above twice it is halved, rounding down. Any smaller request is granted as it stands. When rs1 names x0, the allocation itself is granted. An allocation larger than XLEN is a fault: the unit raises a trap and keeps the old length.

The unit also holds the start-index register that a vector element sequencer uses to resume after a fault. The sequencer can clear it or load a failing index. Both registers can be read and written through a simple control-register port, and the unit rejects out-of-range writes.

A three-state machine sequences the result. `ST_IDLE` is the rest state. `ST_GRANT` lasts one cycle after a non-faulting execute and presents the rd result. `ST_FAULT` lasts one cycle after a faulting execute and presents the trap. Each of the three states moves to `ST_GRANT` on an execute with a legal allocation, to `ST_FAULT` on an execute with an oversized allocation, and to `ST_IDLE` when there is no execute.

Top module: `vlc_top`

## Requirements
- R1: When `exec_i` is high and `imm_i` > XLEN, `trap_o` is high for exactly the next cycle, `rd_valid_o` stays low, and `vl_o` keeps its previous value.
- R2: When `exec_i` is high, `rs1_is_x0_i` is high and `imm_i` <= XLEN, `vl_o` equals `imm_i` after the next clock edge.
- R3: When `exec_i` is high, `rs1_is_x0_i` is low, `imm_i` <= XLEN and `rs1_val_i` > 2*`imm_i`, `vl_o` becomes XLEN.
- R4: When `exec_i` is high, `rs1_is_x0_i` is low, `imm_i` <= XLEN and `imm_i` < `rs1_val_i` <= 2*`imm_i`, `vl_o` becomes floor(`rs1_val_i`/2).
- R5: When `exec_i` is high, `rs1_is_x0_i` is low, `imm_i` <= XLEN and `rs1_val_i` <= `imm_i`, `vl_o` becomes `rs1_val_i`. After every non-faulting execute, `rd_valid_o` is high for exactly the next cycle and `rd_val_o` equals the new `vl_o`.
- R6: `vl_o` never exceeds XLEN and `vstart_o` always stays below XLEN.
- R7: After reset, `vl_o` and `vstart_o` are 0 and `rd_valid_o`, `trap_o` and `csr_illegal_o` are low.
- R8: `seq_clear_i` sets `vstart_o` to 0 at the next edge. `seq_load_i` loads `seq_idx_i` at the next edge. A clear takes priority over a load, and a load takes priority over a control-register write.
- R9: A control-register write with `csr_sel_i`=0 targets VL and with `csr_sel_i`=1 targets the start index. A legal write takes effect at the next edge. `csr_rdata_o` returns the selected register zero-extended, with no delay.
- R10: A control-register write of a VL above XLEN, or of a start index of XLEN or more, leaves both registers unchanged and raises `csr_illegal_o` for exactly the next cycle.
- R11: A VL control-register write that coincides with `exec_i` is dropped, and the execute result is what VL holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe for the set-length instruction |
| rs1_is_x0_i | input | 1 | rs1 names register x0 |
| rs1_val_i | input | XLEN | Requested element count |
| imm_i | input | IMMW | Allocation from the immediate |
| vl_o | output | VLW | Current vector length |
| rd_val_o | output | XLEN | Value to write back to rd |
| rd_valid_o | output | 1 | rd result valid (state ST_GRANT) |
| trap_o | output | 1 | Oversized-allocation trap (state ST_FAULT) |
| seq_clear_i | input | 1 | Sequencer: instruction completed, clear start index |
| seq_load_i | input | 1 | Sequencer: fault, load failing index |
| seq_idx_i | input | VSW | Failing element index |
| vstart_o | output | VSW | Current start index |
| csr_we_i | input | 1 | Control-register write strobe |
| csr_sel_i | input | 1 | Register select: 0 VL, 1 start index |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected register |
| csr_illegal_o | output | 1 | Previous write was out of range |

## Verification
The hardest cases to reach are the exact edges of the grant bands. These are a request equal to the allocation, equal to twice the allocation, and one above twice the allocation, together with an allocation of exactly XLEN against XLEN+1. The stimulus sets each of these pairs on its own execute. Before each run it loads VL through the control-register port to a marker value, so that a grant that keeps the old value cannot pass by accident. The collisions between execute and a VL write, and between sequencer clear, load and a start-index write, are driven in a single cycle so the priority rules decide the result.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_FAULT = 2'd2
    } vlc_state_e;

    typedef enum logic {
        CSR_VL     = 1'b0,
        CSR_VSTART = 1'b1
    } vlc_csr_sel_e;
endpackage

// File: rtl/vlc_grant.sv
module vlc_grant #(
    parameter int XLEN = 64,
    parameter int IMMW = 12,
    parameter int VLW  = $clog2(XLEN + 1)
) (
    input  logic            rs1_is_x0,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [IMMW-1:0] imm,
    output logic            oversize,
    output logic [VLW-1:0]  grant
);
    localparam int WIDE = ((XLEN > IMMW) ? XLEN : IMMW) + 2;

    logic [WIDE-1:0] req_w, alloc_w, alloc2_w, limit_w, half_w;

    always_comb begin
        req_w    = WIDE'(rs1_val);
        alloc_w  = WIDE'(imm);
        alloc2_w = alloc_w << 1;
        limit_w  = WIDE'(XLEN);
        half_w   = req_w >> 1;
        oversize = alloc_w > limit_w;
        if (rs1_is_x0)
            grant = alloc_w[VLW-1:0];
        else if (req_w > alloc2_w)
            grant = VLW'(XLEN);
        else if (req_w > alloc_w)
            grant = half_w[VLW-1:0];
        else
            grant = req_w[VLW-1:0];
    end
endmodule

// File: rtl/vlc_vstart.sv
module vlc_vstart #(
    parameter int XLEN = 64,
    parameter int VSW  = $clog2(XLEN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           seq_clear,
    input  logic           seq_load,
    input  logic [VSW-1:0] seq_idx,
    input  logic           csr_wr,
    input  logic [VSW-1:0] csr_val,
    output logic [VSW-1:0] vstart
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            vstart <= '0;
        else if (seq_clear)
            vstart <= '0;
        else if (seq_load)
            vstart <= seq_idx;
        else if (csr_wr)
            vstart <= csr_val;
    end

    AST_VSTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clear |=> vstart == '0); // R8
    AST_VSTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_clear && seq_load) |=> vstart == $past(seq_idx)); // R8
    AST_VSTART_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vstart) < XLEN); // R6
endmodule

// File: rtl/vlc_top.sv
module vlc_top
    import vlc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 12,
    parameter int VLW  = $clog2(XLEN + 1),
    parameter int VSW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_i,
    input  logic            rs1_is_x0_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [IMMW-1:0] imm_i,
    output logic [VLW-1:0]  vl_o,
    output logic [XLEN-1:0] rd_val_o,
    output logic            rd_valid_o,
    output logic            trap_o,
    input  logic            seq_clear_i,
    input  logic            seq_load_i,
    input  logic [VSW-1:0]  seq_idx_i,
    output logic [VSW-1:0]  vstart_o,
    input  logic            csr_we_i,
    input  logic            csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic [XLEN-1:0] csr_rdata_o,
    output logic            csr_illegal_o
);
    localparam logic [XLEN-1:0] VL_MAX = XLEN'(XLEN);

    vlc_state_e      state_q, state_d;
    logic [VLW-1:0]  vl_q, grant;
    logic [XLEN-1:0] rd_q;
    logic            oversize, illegal_q;
    logic            vl_legal, vs_legal, vl_wr, vs_wr, illegal_d;
    vlc_csr_sel_e    sel;

    vlc_grant #(.XLEN(XLEN), .IMMW(IMMW), .VLW(VLW)) u_grant (
        .rs1_is_x0 (rs1_is_x0_i),
        .rs1_val   (rs1_val_i),
        .imm       (imm_i),
        .oversize  (oversize),
        .grant     (grant)
    );

    vlc_vstart #(.XLEN(XLEN), .VSW(VSW)) u_vstart (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_clear (seq_clear_i),
        .seq_load  (seq_load_i),
        .seq_idx   (seq_idx_i),
        .csr_wr    (vs_wr),
        .csr_val   (csr_wdata_i[VSW-1:0]),
        .vstart    (vstart_o)
    );

    always_comb begin
        sel       = vlc_csr_sel_e'(csr_sel_i);
        vl_legal  = csr_wdata_i <= VL_MAX;
        vs_legal  = csr_wdata_i < VL_MAX;
        vl_wr     = csr_we_i && (sel == CSR_VL) && vl_legal && !exec_i;
        vs_wr     = csr_we_i && (sel == CSR_VSTART) && vs_legal;
        illegal_d = csr_we_i && ((sel == CSR_VL) ? !vl_legal : !vs_legal);
    end

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  if (exec_i) state_d = oversize ? ST_FAULT : ST_GRANT;
            ST_GRANT: if (exec_i) state_d = oversize ? ST_FAULT : ST_GRANT;
            ST_FAULT: if (exec_i) state_d = oversize ? ST_FAULT : ST_GRANT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q      <= '0;
            rd_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= illegal_d;
            if (exec_i && !oversize) begin
                vl_q <= grant;
                rd_q <= XLEN'(grant);
            end else if (vl_wr) begin
                vl_q <= csr_wdata_i[VLW-1:0];
            end
        end
    end

    // output decode
    always_comb begin
        vl_o          = vl_q;
        rd_val_o      = rd_q;
        rd_valid_o    = (state_q == ST_GRANT);
        trap_o        = (state_q == ST_FAULT);
        csr_illegal_o = illegal_q;
        csr_rdata_o   = (sel == CSR_VL) ? XLEN'(vl_q) : XLEN'(vstart_o);
    end

    AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vl_o) <= XLEN); // R6
    AST_TRAP_KEEPS_VL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && 32'(imm_i) > XLEN) |=> (trap_o && !rd_valid_o && $stable(vl_o))); // R1
    AST_X0_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && rs1_is_x0_i && 32'(imm_i) <= XLEN) |=> 32'(vl_o) == 32'($past(imm_i))); // R2
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !rs1_is_x0_i && 32'(imm_i) <= XLEN
         && rs1_val_i > (XLEN'(imm_i) << 1)) |=> 32'(vl_o) == XLEN); // R3
    AST_RD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> rd_val_o == XLEN'(vl_o)); // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_o && trap_o)); // R5
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_sel_i == 1'b0 && csr_wdata_i > VL_MAX && !exec_i)
        |=> (csr_illegal_o && $stable(vl_o))); // R10
endmodule

// File: tb/vlc_top_tb.sv
module vlc_top_tb;
    localparam int XLEN = 64;
    localparam int IMMW = 12;
    localparam int VLW  = $clog2(XLEN + 1);
    localparam int VSW  = $clog2(XLEN);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            exec_i, rs1_is_x0_i;
    logic [XLEN-1:0] rs1_val_i;
    logic [IMMW-1:0] imm_i;
    logic [VLW-1:0]  vl_o;
    logic [XLEN-1:0] rd_val_o;
    logic            rd_valid_o, trap_o;
    logic            seq_clear_i, seq_load_i;
    logic [VSW-1:0]  seq_idx_i;
    logic [VSW-1:0]  vstart_o;
    logic            csr_we_i, csr_sel_i;
    logic [XLEN-1:0] csr_wdata_i, csr_rdata_o;
    logic            csr_illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vlc_top #(.XLEN(XLEN), .IMMW(IMMW)) u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exec_i = 0; rs1_is_x0_i = 0; rs1_val_i = '0; imm_i = '0;
        seq_clear_i = 0; seq_load_i = 0; seq_idx_i = '0;
        csr_we_i = 0; csr_sel_i = 0; csr_wdata_i = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic csr_write(input logic sel, input longint val);
        csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = XLEN'(val);
        step();
        csr_we_i = 0;
    endtask

    task automatic run_exec(input bit x0, input longint rs1, input int imm);
        exec_i = 1; rs1_is_x0_i = x0; rs1_val_i = XLEN'(rs1); imm_i = IMMW'(imm);
        step();
        exec_i = 0; rs1_is_x0_i = 0;
    endtask

    task automatic grant_case(input string req, input bit x0, input longint rs1,
                              input int imm, input int exp_vl);
        csr_write(1'b0, 7);
        run_exec(x0, rs1, imm);
        chk(req, vl_o, exp_vl);
        chk("R5 valid", rd_valid_o, 1);
        chk("R5 rd", rd_val_o, exp_vl);
        chk(req, trap_o, 0);
        step();
        chk("R5 pulse", rd_valid_o, 0);
    endtask

    task automatic t_reset();
        chk("R7 vl", vl_o, 0);
        chk("R7 vstart", vstart_o, 0);
        chk("R7 valid", rd_valid_o, 0);
        chk("R7 trap", trap_o, 0);
        chk("R7 illegal", csr_illegal_o, 0);
    endtask

    task automatic t_grants();
        grant_case("R2 x0", 1, 999, 17, 17);
        grant_case("R2 x0 max", 1, 0, XLEN, XLEN);
        grant_case("R3 sat", 0, 41, 20, XLEN);
        grant_case("R3 edge", 0, 2 * 20 + 1, 20, XLEN);
        grant_case("R4 half edge2x", 0, 40, 20, 20);
        grant_case("R4 half odd", 0, 33, 20, 16);
        grant_case("R4 half imm+1", 0, 21, 20, 10);
        grant_case("R5 equal", 0, 20, 20, 20);
        grant_case("R5 small", 0, 3, 20, 3);
        grant_case("R5 zero", 0, 0, 20, 0);
        grant_case("R3 imm0", 0, 1, 0, XLEN);
    endtask

    task automatic t_trap();
        csr_write(1'b0, 9);
        run_exec(0, 5, XLEN + 1);
        chk("R1 trap", trap_o, 1);
        chk("R1 valid", rd_valid_o, 0);
        chk("R1 vl", vl_o, 9);
        step();
        chk("R1 pulse", trap_o, 0);
        run_exec(1, 0, 4000);
        chk("R1 trap x0", trap_o, 1);
        chk("R1 vl x0", vl_o, 9);
        step();
    endtask

    task automatic t_csr();
        csr_write(1'b0, XLEN);
        chk("R9 vl wr", vl_o, XLEN);
        csr_sel_i = 0; #0.1;
        chk("R9 vl rd", csr_rdata_o, XLEN);
        chk("R9 illegal", csr_illegal_o, 0);
        csr_write(1'b1, XLEN - 1);
        chk("R9 vs wr", vstart_o, XLEN - 1);
        csr_sel_i = 1; #0.1;
        chk("R9 vs rd", csr_rdata_o, XLEN - 1);
        csr_write(1'b0, XLEN + 1);
        chk("R10 vl kept", vl_o, XLEN);
        chk("R10 flag", csr_illegal_o, 1);
        step();
        chk("R10 pulse", csr_illegal_o, 0);
        csr_write(1'b1, XLEN);
        chk("R10 vs kept", vstart_o, XLEN - 1);
        chk("R10 vs flag", csr_illegal_o, 1);
        csr_write(1'b1, 64'h1_0000_0003);
        chk("R10 vs wide", vstart_o, XLEN - 1);
        chk("R6 vs", vstart_o < XLEN, 1);
        step();
    endtask

    task automatic t_seq();
        seq_load_i = 1; seq_idx_i = 6'd13; step(); seq_load_i = 0;
        chk("R8 load", vstart_o, 13);
        seq_clear_i = 1; step(); seq_clear_i = 0;
        chk("R8 clear", vstart_o, 0);
        seq_clear_i = 1; seq_load_i = 1; seq_idx_i = 6'd22;
        csr_we_i = 1; csr_sel_i = 1; csr_wdata_i = 64'd30;
        step();
        chk("R8 clear wins", vstart_o, 0);
        seq_clear_i = 0;
        step();
        chk("R8 load wins", vstart_o, 22);
        seq_load_i = 0;
        step();
        chk("R8 csr after", vstart_o, 30);
        csr_we_i = 0;
    endtask

    task automatic t_collide();
        csr_write(1'b0, 5);
        exec_i = 1; rs1_is_x0_i = 1; imm_i = 12'd11;
        csr_we_i = 1; csr_sel_i = 0; csr_wdata_i = 64'd50;
        step();
        exec_i = 0; rs1_is_x0_i = 0; csr_we_i = 0;
        chk("R11 exec wins", vl_o, 11);
        step();
        chk("R11 held", vl_o, 11);
        chk("R6 vl", vl_o <= XLEN, 1);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_grants();
        t_trap();
        t_csr();
        t_seq();
        t_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule